// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides which power state a small processor subsystem is in, and drives the enables that put each state into effect. Two active states exist. One runs from the fast-starting RC oscillator. The other runs from the crystal oscillator, and it is used only while the radio is wanted. Two retention states exist, a light sleep and a deep sleep, plus a chip-disable state in which everything is off. For each state the block drives the power enables of the CPU, six memory banks, the radio and the DC-DC converter. It also drives the clock source select, a slow-clock indication and a request that boot code rebuild its instruction index table.

Software enters sleep by raising a sleep request. The deep-sleep select, the charge-disable bit and three retention-select bits are captured at that moment. While asleep, a 32-bit wake-up timer counts ticks from either a 32 kHz source or the low-frequency RC oscillator divided by 12. Any interrupt line, or the timer reaching its programmed compare value, starts a wake-up. During wake-up all domains are powered for one cycle while the CPU is still held in reset.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is asserted, the block is in the wake state. All six banks, the CPU and the DC-DC converter are enabled, `cpu_rst_n` is low and `rebuild_idx` is high.
- R2: A wake-up lasts exactly one cycle. In that cycle all domain enables and the DC-DC enable are high and `cpu_rst_n` is low. In the next cycle `cpu_rst_n` goes high.
- R3: While `rf_req` is high in an active state, `xo_en` rises but `clk_sel` stays 0 (RC) until `xo_rdy` is seen. After that, `clk_sel`=1 and `rf_pwr_en`=1. When `rf_req` drops, the block returns to RC with the radio and crystal off. `rf_pwr_en` is only ever high with `clk_sel`=1.
- R4: `dcdc_en` and `cpu_pwr_en` are high in the active and wake states. They are low in sleep, deep sleep and chip-disable. `clk_slow` (reduced controller clock) is high in both sleep states and only there.
- R5: `bank_pwr_en` bit 0 is data bank 0, bits 1 and 2 are data banks 1 and 2, bit 3 is data bank 3, bit 4 is instruction bank 0 and bit 5 is instruction bank 1. In both sleep states bit 0 stays on. Bits 1, 2 and 4 follow `ret_sel[0]`, `ret_sel[1]` and `ret_sel[2]` as captured at sleep entry. Bits 3 and 5 are off.
- R6: `vcc_chg_en` is high in light sleep unless `chg_dis` was set at sleep entry. It is never high in deep sleep or in any other state. Later changes of the select inputs during sleep have no effect.
- R7: In a sleep state, any set bit of `irq` causes the wake state on the next clock edge.
- R8: On every sleep entry the timer restarts at 0. It advances by one per tick while asleep. When it equals `wake_cmp`, `wake_evt` pulses for one cycle and the block wakes on the next edge. A compare value of 0 wakes in the first sleep cycle.
- R9: With `lf_sel`=1 the timer advances once per 12 pulses of `tick_lfrc`. With `lf_sel`=0 it advances once per pulse of `tick_32k`.
- R10: On a wake-up from sleep, `rebuild_idx` is set when instruction bank 0 was not retained and cleared when it was. It is cleared at every sleep or chip-disable entry.
- R11: `chip_dis` has priority over every other input. It drives all enables low and `mode_o`=4. When it is released, a wake-up follows with `rebuild_idx` set.
- R12: `mode_o` encodes 0 active-RC (including the wake and crystal-wait cycles), 1 active-crystal, 2 sleep, 3 deep sleep and 4 chip-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_dis | input | 1 | Chip-disable request |
| sleep_req | input | 1 | Software sleep request |
| deep_sel | input | 1 | Select deep sleep instead of light sleep |
| chg_dis | input | 1 | Do not keep converter output charged in light sleep |
| ret_sel | input | 3 | Retention select: data bank 1, data bank 2, instruction bank 0 |
| rf_req | input | 1 | Radio operation requested |
| irq | input | NIRQ | Interrupt lines |
| xo_rdy | input | 1 | Crystal oscillator ready |
| lf_sel | input | 1 | Timer tick source: 0 32 kHz, 1 LF RC divided by 12 |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| tick_lfrc | input | 1 | One-cycle pulse per LF RC period |
| wake_cmp | input | TW | Wake-up timer compare value |
| cpu_pwr_en | output | 1 | CPU domain power enable |
| cpu_rst_n | output | 1 | CPU reset, active low |
| bank_pwr_en | output | 6 | Memory bank power enables |
| rf_pwr_en | output | 1 | Radio domain power enable |
| dcdc_en | output | 1 | DC-DC converter enable |
| vcc_chg_en | output | 1 | Keep converter output capacitor charged |
| xo_en | output | 1 | Crystal oscillator enable |
| clk_sel | output | 1 | Clock source: 0 RC, 1 crystal |
| clk_slow | output | 1 | Controller clock reduced for sleep |
| rebuild_idx | output | 1 | Request to rebuild instruction index table |
| wake_evt | output | 1 | One-cycle timer match pulse |
| mode_o | output | 3 | Current power mode code |

## Verification
The bound checker watches on every cycle for relationships that hold in every state. It checks that the crystal clock is never selected without the crystal enabled, that the radio is only powered on the crystal clock, that the converter is off whenever the slow clock is indicated, that data bank 0 is never dropped in sleep, and that deep sleep never charges the converter output. It also checks that CPU reset is released only after a cycle of full power, that the timer pulse lasts one cycle, and that chip-disable leaves nothing powered. The exact retention map chosen by captured select bits, the tick counts that lead to a wake-up through each source, the restart of the count at each sleep entry, and the value of the rebuild flag after each kind of wake-up depend on history. Only the bench's scenarios show them.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NBANK = 6;
    localparam int NRET  = 3;

    // bank bit positions in bank_pwr_en
    localparam int BK_D0 = 0;
    localparam int BK_D1 = 1;
    localparam int BK_D2 = 2;
    localparam int BK_D3 = 3;
    localparam int BK_I0 = 4;
    localparam int BK_I1 = 5;

    // ret_sel bit positions
    localparam int RS_D1 = 0;
    localparam int RS_D2 = 1;
    localparam int RS_I0 = 2;

    typedef enum logic [2:0] {
        ST_WAKE    = 3'd0,
        ST_ACT_RC  = 3'd1,
        ST_XO_WAIT = 3'd2,
        ST_ACT_XO  = 3'd3,
        ST_SLEEP   = 3'd4,
        ST_OFF     = 3'd5
    } state_e;

    typedef enum logic [2:0] {
        MD_ACT_RC = 3'd0,
        MD_ACT_XO = 3'd1,
        MD_SLEEP  = 3'd2,
        MD_DEEP   = 3'd3,
        MD_OFF    = 3'd4
    } mode_e;

    typedef struct packed {
        state_e            st;
        logic              deep;
        logic              chg;
        logic [NRET-1:0]   ret;
        logic              rebuild;
    } fsm_regs_t;

endpackage

// File: rtl/pwrseq_lfdiv.sv
module pwrseq_lfdiv #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_sel,
    input  logic tick_32k,
    input  logic tick_lfrc,
    output logic tick_o
);
    localparam int              CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0]   LAST = CW'(DIV - 1);

    logic [CW-1:0] div_d, div_q;
    logic          wrap;

    always_comb begin
        wrap  = tick_lfrc && (div_q == LAST);
        div_d = div_q;
        if (tick_lfrc) begin
            div_d = wrap ? '0 : div_q + 1'b1;
        end
        tick_o = lf_sel ? wrap : tick_32k;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pwrseq_sleep_tmr.sv
module pwrseq_sleep_tmr #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] cmp,
    output logic          match
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          fired;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        match = run && !t_q.fired && (t_q.cnt == cmp);
        t_d   = t_q;
        if (clr) begin
            t_d.cnt   = '0;
            t_d.fired = 1'b0;
        end else if (run) begin
            if (tick)  t_d.cnt   = t_q.cnt + 1'b1;
            if (match) t_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_dis,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic              chg_dis,
    input  logic [NRET-1:0]   ret_sel,
    input  logic              rf_req,
    input  logic [NIRQ-1:0]   irq,
    input  logic              xo_rdy,
    input  logic              wake_hit,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              cpu_pwr_en,
    output logic              cpu_rst_n,
    output logic [NBANK-1:0]  bank_pwr_en,
    output logic              rf_pwr_en,
    output logic              dcdc_en,
    output logic              vcc_chg_en,
    output logic              xo_en,
    output logic              clk_sel,
    output logic              clk_slow,
    output logic              rebuild_idx,
    output logic [2:0]        mode_o
);
    fsm_regs_t r_d, r_q;
    logic      go_sleep;
    logic [NBANK-1:0] keep_mask;

    // next-state logic
    always_comb begin
        r_d      = r_q;
        go_sleep = 1'b0;
        unique case (r_q.st)
            ST_WAKE: begin
                r_d.st = rf_req ? ST_XO_WAIT : ST_ACT_RC;
            end
            ST_ACT_RC: begin
                if (sleep_req)   go_sleep = 1'b1;
                else if (rf_req) r_d.st   = ST_XO_WAIT;
            end
            ST_XO_WAIT: begin
                if (sleep_req)    go_sleep = 1'b1;
                else if (!rf_req) r_d.st   = ST_ACT_RC;
                else if (xo_rdy)  r_d.st   = ST_ACT_XO;
            end
            ST_ACT_XO: begin
                if (sleep_req)    go_sleep = 1'b1;
                else if (!rf_req) r_d.st   = ST_ACT_RC;
            end
            ST_SLEEP: begin
                if ((|irq) || wake_hit) begin
                    r_d.st      = ST_WAKE;
                    r_d.rebuild = !r_q.ret[RS_I0];
                end
            end
            ST_OFF: begin
                if (!chip_dis) begin
                    r_d.st      = ST_WAKE;
                    r_d.rebuild = 1'b1;
                end
            end
            default: r_d.st = ST_WAKE;
        endcase

        if (go_sleep) begin
            r_d.st      = ST_SLEEP;
            r_d.deep    = deep_sel;
            r_d.chg     = !deep_sel && !chg_dis;
            r_d.ret     = ret_sel;
            r_d.rebuild = 1'b0;
        end

        if (chip_dis && r_q.st != ST_OFF) begin
            r_d.st      = ST_OFF;
            r_d.rebuild = 1'b0;
        end

        tmr_clr = (r_d.st == ST_SLEEP) && (r_q.st != ST_SLEEP);
        tmr_run = (r_q.st == ST_SLEEP);
    end

    // retained banks while asleep
    always_comb begin
        keep_mask          = '0;
        keep_mask[BK_D0]   = 1'b1;
        keep_mask[BK_D1]   = r_q.ret[RS_D1];
        keep_mask[BK_D2]   = r_q.ret[RS_D2];
        keep_mask[BK_I0]   = r_q.ret[RS_I0];
    end

    // output decode from registered state
    always_comb begin
        cpu_pwr_en  = 1'b0;
        cpu_rst_n   = 1'b0;
        bank_pwr_en = '0;
        rf_pwr_en   = 1'b0;
        dcdc_en     = 1'b0;
        vcc_chg_en  = 1'b0;
        xo_en       = 1'b0;
        clk_sel     = 1'b0;
        clk_slow    = 1'b0;
        mode_o      = MD_ACT_RC;
        unique case (r_q.st)
            ST_WAKE: begin
                cpu_pwr_en  = 1'b1;
                bank_pwr_en = '1;
                dcdc_en     = 1'b1;
            end
            ST_ACT_RC, ST_XO_WAIT: begin
                cpu_pwr_en  = 1'b1;
                cpu_rst_n   = 1'b1;
                bank_pwr_en = '1;
                dcdc_en     = 1'b1;
                xo_en       = (r_q.st == ST_XO_WAIT);
            end
            ST_ACT_XO: begin
                cpu_pwr_en  = 1'b1;
                cpu_rst_n   = 1'b1;
                bank_pwr_en = '1;
                dcdc_en     = 1'b1;
                xo_en       = 1'b1;
                clk_sel     = 1'b1;
                rf_pwr_en   = 1'b1;
                mode_o      = MD_ACT_XO;
            end
            ST_SLEEP: begin
                bank_pwr_en = keep_mask;
                vcc_chg_en  = r_q.chg;
                clk_slow    = 1'b1;
                mode_o      = r_q.deep ? MD_DEEP : MD_SLEEP;
            end
            ST_OFF: begin
                mode_o      = MD_OFF;
            end
            default: ;
        endcase
        rebuild_idx = r_q.rebuild;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_WAKE;
            r_q.rebuild <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int NIRQ    = 8,
    parameter int TW      = 32,
    parameter int LF_DIV  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_dis,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic              chg_dis,
    input  logic [2:0]        ret_sel,
    input  logic              rf_req,
    input  logic [NIRQ-1:0]   irq,
    input  logic              xo_rdy,
    input  logic              lf_sel,
    input  logic              tick_32k,
    input  logic              tick_lfrc,
    input  logic [TW-1:0]     wake_cmp,
    output logic              cpu_pwr_en,
    output logic              cpu_rst_n,
    output logic [5:0]        bank_pwr_en,
    output logic              rf_pwr_en,
    output logic              dcdc_en,
    output logic              vcc_chg_en,
    output logic              xo_en,
    output logic              clk_sel,
    output logic              clk_slow,
    output logic              rebuild_idx,
    output logic              wake_evt,
    output logic [2:0]        mode_o
);
    logic tick;
    logic tmr_clr;
    logic tmr_run;

    pwrseq_lfdiv #(.DIV(LF_DIV)) lfdiv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lf_sel    (lf_sel),
        .tick_32k  (tick_32k),
        .tick_lfrc (tick_lfrc),
        .tick_o    (tick)
    );

    pwrseq_sleep_tmr #(.TW(TW)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .tick  (tick),
        .cmp   (wake_cmp),
        .match (wake_evt)
    );

    pwrseq_fsm #(.NIRQ(NIRQ)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_dis    (chip_dis),
        .sleep_req   (sleep_req),
        .deep_sel    (deep_sel),
        .chg_dis     (chg_dis),
        .ret_sel     (ret_sel),
        .rf_req      (rf_req),
        .irq         (irq),
        .xo_rdy      (xo_rdy),
        .wake_hit    (wake_evt),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run),
        .cpu_pwr_en  (cpu_pwr_en),
        .cpu_rst_n   (cpu_rst_n),
        .bank_pwr_en (bank_pwr_en),
        .rf_pwr_en   (rf_pwr_en),
        .dcdc_en     (dcdc_en),
        .vcc_chg_en  (vcc_chg_en),
        .xo_en       (xo_en),
        .clk_sel     (clk_sel),
        .clk_slow    (clk_slow),
        .rebuild_idx (rebuild_idx),
        .mode_o      (mode_o)
    );
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rst_n,
    input logic [5:0] bank_pwr_en,
    input logic       dcdc_en,
    input logic       rf_pwr_en,
    input logic       vcc_chg_en,
    input logic       xo_en,
    input logic       clk_sel,
    input logic       clk_slow,
    input logic       wake_evt,
    input logic [2:0] mode_o
);
    AST_XO_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) clk_sel |-> xo_en); // R3
    AST_RF_ON_XO_ONLY: assert property (@(posedge clk) disable iff (!rst_n) rf_pwr_en |-> clk_sel); // R3
    AST_SLOW_DCDC_OFF: assert property (@(posedge clk) disable iff (!rst_n) clk_slow |-> !dcdc_en); // R4
    AST_D0_KEPT: assert property (@(posedge clk) disable iff (!rst_n) clk_slow |-> bank_pwr_en[0]); // R5
    AST_DEEP_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n) (mode_o == 3'd3) |-> !vcc_chg_en); // R6
    AST_CHG_ONLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) vcc_chg_en |-> (mode_o == 3'd2)); // R6
    AST_RST_AFTER_PWR: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_rst_n) |-> ($past(dcdc_en) && ($past(bank_pwr_en) == 6'h3F))); // R2
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wake_evt |=> !wake_evt); // R8
    AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) (clk_slow && wake_evt) |=> !clk_slow); // R8
    AST_OFF_ALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (mode_o == 3'd4) |-> ((bank_pwr_en == 6'h00) && !dcdc_en && !xo_en)); // R11
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk chk_i (.*);

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;

    localparam int NIRQ = 8;
    localparam int TW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            chip_dis = 1'b0, sleep_req = 1'b0, deep_sel = 1'b0, chg_dis = 1'b0;
    logic [2:0]      ret_sel = 3'b000;
    logic            rf_req = 1'b0, xo_rdy = 1'b0, lf_sel = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic            tick_32k = 1'b0, tick_lfrc = 1'b0;
    logic [TW-1:0]   wake_cmp = 32'd1000;

    logic       cpu_pwr_en, cpu_rst_n, rf_pwr_en, dcdc_en, vcc_chg_en;
    logic       xo_en, clk_sel, clk_slow, rebuild_idx, wake_evt;
    logic [5:0] bank_pwr_en;
    logic [2:0] mode_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pwrseq_ctrl #(.NIRQ(NIRQ), .TW(TW), .LF_DIV(12)) dut_i (.*);

    // stim: chip_dis sleep_req deep_sel chg_dis ret_sel rf_req irq xo_rdy
    // exp : mode banks cpu dcdc rf chg sel xo rstn rebuild slow
    typedef struct packed {
        logic       s_chip;
        logic       s_sleep;
        logic       s_deep;
        logic       s_chgdis;
        logic [2:0] s_ret;
        logic       s_rf;
        logic [7:0] s_irq;
        logic       s_xo;
        logic [2:0] e_mode;
        logic [5:0] e_bank;
        logic [8:0] e_flag;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd0,6'b111111,9'b110000110},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,8'h00,1'b0, 3'd0,6'b111111,9'b110001110},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,8'h00,1'b0, 3'd0,6'b111111,9'b110001110},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,8'h00,1'b1, 3'd1,6'b111111,9'b111011110},
        '{1'b0,1'b1,1'b0,1'b0,3'b100,1'b1,8'h00,1'b1, 3'd2,6'b010001,9'b000100001},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd2,6'b010001,9'b000100001},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h04,1'b0, 3'd0,6'b111111,9'b110000000},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd0,6'b111111,9'b110000100},
        '{1'b0,1'b1,1'b1,1'b0,3'b011,1'b0,8'h00,1'b0, 3'd3,6'b000111,9'b000000001},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h01,1'b0, 3'd0,6'b111111,9'b110000010},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,8'h00,1'b0, 3'd0,6'b111111,9'b110001110},
        '{1'b0,1'b1,1'b0,1'b1,3'b000,1'b0,8'h00,1'b0, 3'd2,6'b000001,9'b000000001},
        '{1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd4,6'b000000,9'b000000000},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd0,6'b111111,9'b110000010},
        '{1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,8'h00,1'b0, 3'd0,6'b111111,9'b110000110}
    };
    localparam string ROW_REQ [NVEC] = '{"R2","R3","R3","R3","R5","R6","R7","R10",
                                         "R12","R10","R3","R5","R11","R11","R2"};

    function automatic logic [17:0] snap();
        return {mode_o, bank_pwr_en, cpu_pwr_en, dcdc_en, rf_pwr_en, vcc_chg_en,
                clk_sel, xo_en, cpu_rst_n, rebuild_idx, clk_slow};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        chip_dis = 1'b0; sleep_req = 1'b0; deep_sel = 1'b0; chg_dis = 1'b0;
        ret_sel = 3'b000; rf_req = 1'b0; irq = '0; xo_rdy = 1'b0;
    endtask

    task automatic pulse_32k();
        tick_32k = 1'b1; step(); tick_32k = 1'b0;
    endtask

    task automatic pulse_lfrc();
        tick_lfrc = 1'b1; step(); tick_lfrc = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        chk("R1", 32'(snap()), 32'({3'd0, 6'b111111, 9'b110000010}));
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            chip_dis = TBL[i].s_chip;   sleep_req = TBL[i].s_sleep;
            deep_sel = TBL[i].s_deep;   chg_dis   = TBL[i].s_chgdis;
            ret_sel  = TBL[i].s_ret;    rf_req    = TBL[i].s_rf;
            irq      = TBL[i].s_irq;    xo_rdy    = TBL[i].s_xo;
            step();
            chk(ROW_REQ[i], 32'(snap()), 32'({TBL[i].e_mode, TBL[i].e_bank, TBL[i].e_flag}));
        end
        idle_in();

        // R8: 32 kHz ticks, compare value 3
        wake_cmp = 32'd3; lf_sel = 1'b0;
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk("R4", 32'({dcdc_en, cpu_pwr_en, clk_slow}), 32'(3'b001));
        chk("R8", 32'(wake_evt), 32'd0);
        pulse_32k(); pulse_32k();
        chk("R8", 32'({wake_evt, mode_o}), 32'({1'b0, 3'd2}));
        pulse_32k();
        chk("R8", 32'(wake_evt), 32'd1);
        step();
        chk("R8", 32'({wake_evt, mode_o, cpu_rst_n, rebuild_idx}), 32'({1'b0, 3'd0, 1'b0, 1'b1}));
        step();
        chk("R2", 32'(cpu_rst_n), 32'd1);

        // R9: LF RC divided by 12, compare 1; count restarts at sleep entry
        wake_cmp = 32'd1; lf_sel = 1'b1;
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk("R8", 32'(wake_evt), 32'd0);
        for (int k = 0; k < 11; k++) pulse_lfrc();
        chk("R9", 32'({wake_evt, mode_o}), 32'({1'b0, 3'd2}));
        pulse_lfrc();
        chk("R9", 32'(wake_evt), 32'd1);
        step();
        chk("R9", 32'(mode_o), 32'd0);
        step();

        // R8: compare 0 wakes in first sleep cycle
        wake_cmp = 32'd0; lf_sel = 1'b0;
        sleep_req = 1'b1; deep_sel = 1'b1; ret_sel = 3'b100; step(); idle_in();
        chk("R8", 32'({wake_evt, mode_o}), 32'({1'b1, 3'd3}));
        step();
        chk("R10", 32'({mode_o, cpu_rst_n, rebuild_idx}), 32'({3'd0, 1'b0, 1'b0}));
        step();

        // R3: crystal path and return to RC when radio request drops
        rf_req = 1'b1; xo_rdy = 1'b1; step();
        chk("R3", 32'({clk_sel, xo_en, rf_pwr_en}), 32'(3'b010));
        step();
        chk("R3", 32'({clk_sel, xo_en, rf_pwr_en, mode_o}), 32'({3'b111, 3'd1}));
        rf_req = 1'b0; step();
        chk("R3", 32'({clk_sel, xo_en, rf_pwr_en, mode_o}), 32'({3'b000, 3'd0}));

        // R7: interrupt ignored while active
        irq = 8'h80; step(); irq = '0;
        chk("R7", 32'({mode_o, cpu_rst_n}), 32'({3'd0, 1'b1}));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule